// File: doc/BRIEF.md
# Programmable External Interrupt Pin Detector

This block turns an asynchronous external request line into a sticky interrupt flag. The line is first brought into the clock domain through a chain of flip-flops. A detector then decides, from a software-chosen polarity and mode, whether the current sample counts as a request event. In edge mode only a transition into the active level counts. In level mode any sample at the active level counts, which covers the edge as well. The polarity bit makes one choice that covers both: falling edges and low level, or rising edges and high level.

Software drives a single 8-bit control/status register. It holds the mode, the enable and the polarity. It shows the flag, and it has a write-only acknowledge bit that clears the flag. The interrupt output is the flag gated by the enable. With the enable clear, software polls the flag instead.

Top module: `irq_pin_detect`

## Requirements
- R1: After reset the register reads 0x00 and `irq_o` is 0. This means falling/low polarity, edge mode, interrupt disabled and flag clear.
- R2: Register layout. Bit 0 is the mode (0 edge, 1 edge-and-level). Bit 1 is the interrupt enable. Bit 2 is the acknowledge, which is write-only and always reads 0. Bit 3 is the flag, which is read-only. Bit 5 is the polarity (0 falling/low, 1 rising/high). Bits 7, 6 and 4 read 0. Mode, enable and polarity take the written value on the cycle after `wr_en_i` and hold otherwise.
- R3: The pin passes through a two-flop synchronizer. A change on `pin_i` before clock edge k can set the flag at edge k+2 at the earliest.
- R4: In edge mode with polarity 0, a 1-to-0 transition of the synchronized pin sets the flag, and a 0-to-1 transition does not.
- R5: In edge mode with polarity 1, a 0-to-1 transition sets the flag, and a 1-to-0 transition does not.
- R6: In level mode, every cycle the synchronized pin sits at the active level sets the flag. After an acknowledge, the flag reads 0 for one cycle and is set again on the next cycle if the pin is still active.
- R7: The flag stays set until an acknowledge is written. The pin going inactive does not clear it, and a write with bit 2 at 0 does not clear it.
- R8: If an acknowledge write and a detection event fall in the same cycle, the acknowledge wins and the flag is 0 afterwards.
- R9: `irq_o` equals the flag AND the enable. With the enable at 0, the flag still sets but `irq_o` stays 0.
- R10: A register write that changes the polarity while the pin is steady does not set the flag in edge mode.
- R11: Writing 1 to bit 3 does not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous external request line |
| wr_en_i | input | 1 | Register write strobe for one cycle |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value |
| irq_o | output | 1 | Interrupt request (flag AND enable) |

## Verification
A stale edge history shows up at the ports as a flag bit that sets with no real transition, or stays clear after one. This is seen three clock edges after the pin or polarity change that exposes it. A wrong synchronizer depth moves every flag set earlier or later by whole cycles. The per-cycle comparison against the reference model therefore catches it on the first pin event. Errors in acknowledge priority or level re-arming show in bit 3 within one or two cycles of the acknowledge write.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int REG_W  = 8;
  localparam int MODE_B = 0;
  localparam int EN_B   = 1;
  localparam int ACK_B  = 2;
  localparam int FLAG_B = 3;
  localparam int POL_B  = 5;

  typedef struct packed {
    logic pol;
    logic en;
    logic mode;
  } irqd_cfg_t;

  // Sample is at the active level for the chosen polarity
  function automatic logic is_active(logic lvl, logic pol);
    return lvl == pol;
  endfunction

  // Detection rule: level mode takes any active sample, edge mode a new one
  function automatic logic detect(logic mode, logic act, logic hist);
    return mode ? act : (act & ~hist);
  endfunction
endpackage

// File: rtl/irqd_sync.sv
module irqd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_chk
      AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q[i] == $past(stg_q[i-1])); // R3
    end
  endgenerate
endmodule

// File: rtl/irqd_detect.sv
module irqd_detect
  import irqd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl_i,
  input  irqd_cfg_t cfg_i,
  input  logic      reload_i,
  input  logic      reload_pol_i,
  output logic      active_o,
  output logic      event_o
);
  logic hist_q;

  assign active_o = is_active(lvl_i, cfg_i.pol);
  assign event_o  = detect(cfg_i.mode, active_o, hist_q);

  // History holds activity under the current polarity; a write reloads it
  // under the polarity being written so a polarity flip is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= 1'b0;
    else if (reload_i) hist_q <= is_active(lvl_i, reload_pol_i);
    else               hist_q <= active_o;
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.mode && event_o && !reload_i) |=> !event_o); // R4

  AST_NO_FALSE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cfg_i.mode || (lvl_i != $past(lvl_i)) || !event_o)); // R10
endmodule

// File: rtl/irqd_ctrl.sv
module irqd_ctrl
  import irqd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             event_i,
  output irqd_cfg_t        cfg_o,
  output logic             flag_o,
  output logic             ack_o,
  output logic [REG_W-1:0] rd_data_o
);
  irqd_cfg_t cfg_q;
  logic      flag_q;

  assign ack_o = wr_en_i & wr_data_i[ACK_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        cfg_q.pol  <= wr_data_i[POL_B];
        cfg_q.en   <= wr_data_i[EN_B];
        cfg_q.mode <= wr_data_i[MODE_B];
      end
      if (ack_o)        flag_q <= 1'b0;
      else if (event_i) flag_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o         = '0;
    rd_data_o[POL_B]  = cfg_q.pol;
    rd_data_o[FLAG_B] = flag_q;
    rd_data_o[EN_B]   = cfg_q.en;
    rd_data_o[MODE_B] = cfg_q.mode;
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(cfg_q)); // R2

  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(event_i)); // R7

  AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(ack_o)); // R7

  AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !flag_q); // R8
endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect
  import irqd_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o
);
  logic      pin_sync;
  logic      pin_active;
  logic      det_event;
  logic      flag;
  logic      ack;
  irqd_cfg_t cfg;

  irqd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  irqd_detect u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .lvl_i        (pin_sync),
    .cfg_i        (cfg),
    .reload_i     (wr_en_i),
    .reload_pol_i (wr_data_i[POL_B]),
    .active_o     (pin_active),
    .event_o      (det_event)
  );

  irqd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .event_i   (det_event),
    .cfg_o     (cfg),
    .flag_o    (flag),
    .ack_o     (ack),
    .rd_data_o (rd_data_o)
  );

  assign irq_o = flag & cfg.en;

  AST_LEVEL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode && pin_active && !ack) |=> flag); // R6

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_data_i[EN_B]) |=> !irq_o); // R9
endmodule

// File: tb/irq_pin_detect_tb.sv
`timescale 1ns/1ps
module irq_pin_detect_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  irq_pin_detect u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  // Behavioural reference model
  bit m_pipe[$] = '{1'b1, 1'b1};
  bit m_hist, m_pol, m_en, m_mode, m_flag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pipe = '{1'b1, 1'b1};
      m_hist = 0; m_pol = 0; m_en = 0; m_mode = 0; m_flag = 0;
    end else begin
      bit lvl, act, ev, ack;
      lvl = m_pipe[1];
      act = (lvl == m_pol);
      ev  = m_mode ? act : (act && !m_hist);
      ack = wr_en && wr_data[2];
      m_hist = wr_en ? (lvl == wr_data[5]) : act;
      if (ack) m_flag = 0;
      else if (ev) m_flag = 1;
      if (wr_en) begin
        m_pol = wr_data[5]; m_en = wr_data[1]; m_mode = wr_data[0];
      end
      m_pipe.push_front(pin);
      void'(m_pipe.pop_back());
    end
  end

  function automatic logic [7:0] m_read();
    return {2'b00, m_pol, 1'b0, m_flag, 1'b0, m_en, m_mode};
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(cur_req, "reg", rd_data, m_read());
      chk(cur_req, "irq", {7'b0, irq}, {7'b0, m_flag & m_en});
    end
  end

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic setpin(logic v);
    @(negedge clk); pin = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample();
    @(posedge clk); #3;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    sample();
    chk("R1", "reset reg", rd_data, 8'h00);
    chk("R1", "reset irq", {7'b0, irq}, 8'h00);

    // R2 layout: pol, ack, en, mode written; ack reads 0
    cur_req = "R2";
    wr(8'hF7);
    sample();
    chk("R2", "layout", rd_data & 8'hF7, 8'h23);
    wr(8'h04);
    wr(8'h00);

    // R4 falling edge, pol 0 edge mode
    cur_req = "R4";
    wr(8'h06);
    setpin(1'b0);
    // R3: no flag before the third edge
    cur_req = "R3";
    sample();
    chk("R3", "flag after 1 edge", {7'b0, rd_data[3]}, 8'h00);
    sample();
    chk("R3", "flag after 2 edges", {7'b0, rd_data[3]}, 8'h00);
    cur_req = "R4";
    idle(3);
    chk("R4", "falling sets", {7'b0, rd_data[3]}, 8'h01);
    chk("R9", "irq enabled", {7'b0, irq}, 8'h01);
    wr(8'h06);
    setpin(1'b1);
    idle(5);
    chk("R4", "rising ignored", {7'b0, rd_data[3]}, 8'h00);

    // R5 rising edge, pol 1
    cur_req = "R5";
    setpin(1'b0);
    idle(4);
    wr(8'h26);
    setpin(1'b1);
    idle(5);
    chk("R5", "rising sets", {7'b0, rd_data[3]}, 8'h01);
    wr(8'h26);
    setpin(1'b0);
    idle(5);
    chk("R5", "falling ignored", {7'b0, rd_data[3]}, 8'h00);

    // R7 sticky flag
    cur_req = "R7";
    setpin(1'b1);
    idle(5);
    setpin(1'b0);
    idle(8);
    wr(8'h22);
    idle(2);
    chk("R7", "sticky", {7'b0, rd_data[3]}, 8'h01);

    // R11 flag bit not writable
    cur_req = "R11";
    wr(8'h26);
    idle(2);
    wr(8'h2A);
    idle(2);
    chk("R11", "flag write ignored", {7'b0, rd_data[3]}, 8'h00);

    // R10 polarity flip with steady pin
    cur_req = "R10";
    wr(8'h02);
    setpin(1'b1);
    idle(5);
    wr(8'h26);
    wr(8'h22);
    idle(4);
    chk("R10", "no false edge", {7'b0, rd_data[3]}, 8'h00);
    wr(8'h02);
    idle(4);
    chk("R10", "flip back", {7'b0, rd_data[3]}, 8'h00);

    // R8 ack coincides with event
    cur_req = "R8";
    @(negedge clk); pin = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h06;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
    idle(3);
    chk("R8", "ack wins", {7'b0, rd_data[3]}, 8'h00);

    // R6 level mode re-arm
    cur_req = "R6";
    wr(8'h03);
    idle(3);
    chk("R6", "level sets", {7'b0, rd_data[3]}, 8'h01);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h07;
    @(posedge clk); #3;
    chk("R6", "cleared one cycle", {7'b0, rd_data[3]}, 8'h00);
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
    @(posedge clk); #3;
    chk("R6", "re-armed", {7'b0, rd_data[3]}, 8'h01);

    // R9 polling with enable off
    cur_req = "R9";
    wr(8'h01);
    idle(3);
    chk("R9", "flag set", {7'b0, rd_data[3]}, 8'h01);
    chk("R9", "irq gated", {7'b0, irq}, 8'h00);

    // Random mix checked by the model each cycle
    cur_req = "R3";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pin = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 9) == 0) begin
        wr_en = 1'b1;
        wr_data = 8'($urandom_range(0, 255));
      end else begin
        wr_en = 1'b0;
        wr_data = 8'h00;
      end
    end
    @(negedge clk); wr_en = 1'b0;
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule